// File: doc/BRIEF.md
# Receive Credit Update Scheduler

This block sits on the receiving end of a flow-controlled link. It tracks how much buffer space has been handed back to the far-end sender for one traffic class, with header and data kept apart. Each allocated counter starts at the buffer capacity for its kind. It grows when the local application has finished pulling a whole packet out of the receive buffer. One header credit is returned per packet, plus the packet's data credits.

The block remembers the header and data values that were last advertised to the sender. It also keeps a running total of the data credits that have arrived. From these it decides whether a credit update needs to go out and how urgent it is. A request is raised at low priority whenever there is something new to advertise, or when the resend interval has run out. The request is promoted to high priority when any of three conditions holds:

- the sender is about to run out of data credits;
- the resend interval has elapsed;
- a large share of the buffer is being held back from the sender.

A link arbiter outside this block sends the update and pulses an acknowledgement. It then latches the advertised values presented on that cycle.

Top module: `fc_update_sched`

## Requirements
- R1: During and after reset, `adv_hdr` equals HDR_CAP (32), `adv_dat` equals DAT_CAP (256), and `upd_req` and `upd_hi` are 0.
- R2: A cycle with `drain_vld` high adds 1 to `adv_hdr` and `drain_dat` to `adv_dat`, modulo 2^CW. The new values appear on the outputs one cycle later. Without `drain_vld` both stay unchanged.
- R3: A cycle with `sent_ack` high records the `adv_hdr` and `adv_dat` present on that cycle as the last advertised values, and restarts the resend timer.
- R4: `upd_req` is 1 exactly when `adv_hdr` or `adv_dat` differs from its last advertised value, or when the resend timer has expired. It therefore stays high until an acknowledgement catches up with the allocated values.
- R5: `upd_hi` is 1 when the sender is starving. That means two things both hold: (last advertised data minus total received data) modulo 2^CW is below MAXP (16), and `adv_dat` differs from the last advertised data.
- R6: `upd_hi` and `upd_req` are 1 once TIMER_CYCLES = CLK_MHZ*RESEND_US (7500) clock edges have passed since reset or the last acknowledgement. With no acknowledgement they stay 1.
- R7: `upd_hi` is 1 when (`adv_hdr` minus last advertised header) modulo 2^CW is at least HDR_CAP/4 (8). The same holds when (`adv_dat` minus last advertised data) is at least DAT_CAP/4 (64).
- R8: A cycle with `rcv_vld` high adds `rcv_dat` to the total received data. The total only enters the starvation rule and never changes `adv_hdr` or `adv_dat`.
- R9: `upd_hi` is never 1 while `upd_req` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| drain_vld | input | 1 | A whole packet has been read out of the receive buffer |
| drain_dat | input | CW (12) | Data credits freed by that packet |
| rcv_vld | input | 1 | A packet has arrived from the link |
| rcv_dat | input | CW (12) | Data credits carried by that packet |
| sent_ack | input | 1 | The credit update presented this cycle has been sent |
| adv_hdr | output | CW (12) | Header credits allocated, the value to advertise |
| adv_dat | output | CW (12) | Data credits allocated, the value to advertise |
| upd_req | output | 1 | An update should be sent |
| upd_hi | output | 1 | The update request is urgent |

## Verification
The hardest situation to reach is starvation. The received total must climb to within MAXP of the last advertised data limit while no acknowledgement arrives. Then a single small drain must make the allocated value move past that limit. Random traffic seldom lines these up, so a directed sequence after reset does it step by step. It feeds 245 data credits without any drain and checks that no urgency appears. It then drains one credit. The resend timer also needs its own stretch: roughly 7500 cycles with no acknowledgement and no drain, with a check one cycle before expiry and one on expiry.

// File: rtl/fcu_pkg.sv
package fcu_pkg;
  // Per-class flags produced from a lane's next state
  typedef struct packed {
    logic pend;     // allocated differs from last advertised
    logic quarter;  // unadvertised credits reach a quarter of capacity
  } lane_flags_t;
endpackage

// File: rtl/fcu_credit_lane.sv
module fcu_credit_lane
  import fcu_pkg::*;
#(
  parameter int W   = 12,
  parameter int CAP = 256
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc_vld,
  input  logic [W-1:0] inc,
  input  logic         ack,
  output logic [W-1:0] alloc_q,
  output logic [W-1:0] last_q,
  output logic [W-1:0] last_nx,
  output lane_flags_t  flags_nx
);
  localparam logic [W-1:0] CAP_W = W'(CAP);
  localparam logic [W-1:0] QTR_W = W'(CAP / 4);

  logic [W-1:0] alloc_nx;
  logic [W-1:0] gap_nx;

  always_comb begin
    alloc_nx         = inc_vld ? alloc_q + inc : alloc_q;
    last_nx          = ack ? alloc_q : last_q;
    gap_nx           = alloc_nx - last_nx;
    flags_nx.pend    = (gap_nx != '0);
    flags_nx.quarter = (gap_nx >= QTR_W);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      alloc_q <= CAP_W;
      last_q  <= CAP_W;
    end else begin
      alloc_q <= alloc_nx;
      last_q  <= last_nx;
    end
  end

  // R2: allocation only moves on a drain event
  a_r2_hold_without_drain: assert property (@(posedge clk) disable iff (rst)
    !inc_vld |=> alloc_q == $past(alloc_q));

  // R3: acknowledgement captures the value presented on that cycle
  a_r3_ack_captures: assert property (@(posedge clk) disable iff (rst)
    ack |=> last_q == $past(alloc_q));
endmodule

// File: rtl/fcu_resend_timer.sv
module fcu_resend_timer #(
  parameter int TERM = 7500
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  output logic expired_nx
);
  localparam int CTW = $clog2(TERM + 1);
  localparam logic [CTW-1:0] TERM_C = CTW'(TERM);

  logic [CTW-1:0] cnt_q;
  logic [CTW-1:0] cnt_nx;

  always_comb begin
    if (restart)              cnt_nx = '0;
    else if (cnt_q == TERM_C) cnt_nx = cnt_q;
    else                      cnt_nx = cnt_q + 1'b1;
    expired_nx = (cnt_nx == TERM_C);
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_nx;
  end

  // R6: the interval restarts on every acknowledgement
  a_r6_restart_clears: assert property (@(posedge clk) disable iff (rst)
    restart |=> cnt_q == '0);
endmodule

// File: rtl/fc_update_sched.sv
module fc_update_sched
  import fcu_pkg::*;
#(
  parameter int CW        = 12,
  parameter int HDR_CAP   = 32,
  parameter int DAT_CAP   = 256,
  parameter int MAXP      = 16,
  parameter int CLK_MHZ   = 250,
  parameter int RESEND_US = 30
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          drain_vld,
  input  logic [CW-1:0] drain_dat,
  input  logic          rcv_vld,
  input  logic [CW-1:0] rcv_dat,
  input  logic          sent_ack,
  output logic [CW-1:0] adv_hdr,
  output logic [CW-1:0] adv_dat,
  output logic          upd_req,
  output logic          upd_hi
);
  localparam int TIMER_CYCLES = CLK_MHZ * RESEND_US;
  localparam logic [CW-1:0] MAXP_W = CW'(MAXP);

  lane_flags_t  hdr_f, dat_f;
  logic [CW-1:0] hdr_last, dat_last, hdr_last_nx, dat_last_nx;
  logic [CW-1:0] tot_q, tot_nx;
  logic          tmr_exp_nx, starve_nx;
  logic [CW-1:0] hdr_inc;

  assign hdr_inc = {{(CW-1){1'b0}}, 1'b1};

  fcu_credit_lane #(.W(CW), .CAP(HDR_CAP)) u_hdr_lane (
    .clk(clk), .rst(rst), .inc_vld(drain_vld), .inc(hdr_inc), .ack(sent_ack),
    .alloc_q(adv_hdr), .last_q(hdr_last), .last_nx(hdr_last_nx), .flags_nx(hdr_f)
  );

  fcu_credit_lane #(.W(CW), .CAP(DAT_CAP)) u_dat_lane (
    .clk(clk), .rst(rst), .inc_vld(drain_vld), .inc(drain_dat), .ack(sent_ack),
    .alloc_q(adv_dat), .last_q(dat_last), .last_nx(dat_last_nx), .flags_nx(dat_f)
  );

  fcu_resend_timer #(.TERM(TIMER_CYCLES)) u_timer (
    .clk(clk), .rst(rst), .restart(sent_ack), .expired_nx(tmr_exp_nx)
  );

  always_comb begin
    tot_nx    = rcv_vld ? tot_q + rcv_dat : tot_q;
    starve_nx = ((dat_last_nx - tot_nx) < MAXP_W) && dat_f.pend;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tot_q   <= '0;
      upd_req <= 1'b0;
      upd_hi  <= 1'b0;
    end else begin
      tot_q   <= tot_nx;
      upd_req <= hdr_f.pend | dat_f.pend | tmr_exp_nx;
      upd_hi  <= starve_nx | tmr_exp_nx | hdr_f.quarter | dat_f.quarter;
    end
  end

  // R9: urgency only accompanies a raised request
  a_r9_hi_implies_req: assert property (@(posedge clk) disable iff (rst)
    upd_hi |-> upd_req);

  // R8: received data never moves the advertised values
  a_r8_rcv_keeps_adv: assert property (@(posedge clk) disable iff (rst)
    (rcv_vld && !drain_vld) |=> adv_dat == $past(adv_dat));

  // unused last-advertised copies kept for visibility
  logic unused_last;
  assign unused_last = ^{hdr_last, dat_last};
endmodule

// File: tb/fc_update_sched_bench.sv
module fc_update_sched_bench;
  localparam int CLK_PERIOD = 4;
  localparam int CW = 12;
  localparam int HDR_CAP = 32;
  localparam int DAT_CAP = 256;
  localparam int MAXP = 16;
  localparam int TERM = 250 * 30;

  logic clk = 0, rst = 1;
  logic drain_vld = 0, rcv_vld = 0, sent_ack = 0;
  logic [CW-1:0] drain_dat = '0, rcv_dat = '0;
  logic [CW-1:0] adv_hdr, adv_dat;
  logic upd_req, upd_hi;

  always #(CLK_PERIOD/2) clk = ~clk;

  fc_update_sched u_fc_update_sched (
    .clk(clk), .rst(rst), .drain_vld(drain_vld), .drain_dat(drain_dat),
    .rcv_vld(rcv_vld), .rcv_dat(rcv_dat), .sent_ack(sent_ack),
    .adv_hdr(adv_hdr), .adv_dat(adv_dat), .upd_req(upd_req), .upd_hi(upd_hi)
  );

  int checks = 0, fails = 0;
  bit done = 0;

  // reference state
  logic [CW-1:0] mh, md, lh, ld, tot;
  int tmr;

  function automatic bit exp_req();
    return (mh != lh) || (md != ld) || (tmr == TERM);
  endfunction

  function automatic bit exp_hi();
    bit starve, quarter;
    starve  = (CW'(ld - tot) < CW'(MAXP)) && (md != ld);
    quarter = (CW'(mh - lh) >= CW'(HDR_CAP/4)) || (CW'(md - ld) >= CW'(DAT_CAP/4));
    return starve || quarter || (tmr == TERM);
  endfunction

  task automatic model_reset();
    mh = CW'(HDR_CAP); md = CW'(DAT_CAP); lh = mh; ld = md; tot = '0; tmr = 0;
  endtask

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_all();
    chk("R2 adv_hdr", adv_hdr, mh);
    chk("R2 adv_dat", adv_dat, md);
    chk("R4 upd_req", upd_req, exp_req());
    chk("R5/R6/R7 upd_hi", upd_hi, exp_hi());
    chk("R9 hi needs req", (upd_hi && !upd_req), 0);
  endtask

  task automatic step(bit dv, int dd, bit rv, int rd, bit ack);
    drain_vld = dv; drain_dat = CW'(dd); rcv_vld = rv; rcv_dat = CW'(rd); sent_ack = ack;
    @(posedge clk);
    if (ack) begin lh = mh; ld = md; end   // R3
    if (dv) begin mh = mh + 1'b1; md = md + CW'(dd); end
    if (rv) tot = tot + CW'(rd);          // R8
    tmr = ack ? 0 : ((tmr == TERM) ? TERM : tmr + 1);
    @(negedge clk);
    drain_vld = 0; rcv_vld = 0; sent_ack = 0;
    check_all();
  endtask

  task automatic do_reset();
    rst = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    model_reset();
    chk("R1 reset hdr", adv_hdr, HDR_CAP);
    chk("R1 reset dat", adv_dat, DAT_CAP);
    chk("R1 reset req", upd_req, 0);
    chk("R1 reset hi", upd_hi, 0);
    rst = 0;
  endtask

  initial begin
    void'($urandom(32'd1357));
    model_reset();
    do_reset();

    // R7 data quarter: 63 credits stay low, the 64th goes urgent
    step(1, 63, 0, 0, 0);
    chk("R7 below quarter", upd_hi, 0);
    step(1, 1, 0, 0, 0);
    chk("R7 data quarter", upd_hi, 1);
    step(0, 0, 0, 0, 1);
    chk("R3 ack drops req", upd_req, 0);

    // R7 header quarter: 7 packets low, 8th urgent
    for (int i = 0; i < 7; i++) step(1, 0, 0, 0, 0);
    chk("R7 hdr below quarter", upd_hi, 0);
    chk("R4 req pending", upd_req, 1);
    step(1, 0, 0, 0, 0);
    chk("R7 hdr quarter", upd_hi, 1);

    // R5 starvation from a fresh reset
    do_reset();
    for (int i = 0; i < 16; i++) step(0, 0, 1, 15, 0);
    step(0, 0, 1, 5, 0);
    chk("R8 rcv keeps adv", adv_dat, DAT_CAP);
    chk("R5 no drain no hi", upd_hi, 0);
    step(1, 1, 0, 0, 0);
    chk("R5 starvation", upd_hi, 1);

    // R6 resend timer
    step(0, 0, 0, 0, 1);
    for (int i = 0; i < TERM - 1; i++) step(0, 0, 0, 0, 0);
    chk("R6 before expiry", upd_req, 0);
    step(0, 0, 0, 0, 0);
    chk("R6 expiry req", upd_req, 1);
    chk("R6 expiry hi", upd_hi, 1);
    step(0, 0, 0, 0, 0);
    chk("R6 stays expired", upd_hi, 1);
    step(0, 0, 0, 0, 1);
    chk("R3 ack restarts timer", upd_req, 0);

    // random mix
    do_reset();
    for (int i = 0; i < 4000; i++)
      step(($urandom % 3) == 0, $urandom % 16, ($urandom % 3) == 0, $urandom % 16,
           ($urandom % 12) == 0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule